// File: doc/BRIEF.md
# Link-Level CRC Retry Engine

This block is the link layer of one end of a point-to-point link. On the transmit side it takes a stream of 65-bit flits and groups them sixteen at a time into link packets. It sends each flit out one cycle after accepting it and adds a trailer beat that carries the packet's sequence number and a CRC-16 computed while the flits stream past. Every packet it sends stays in a local replay store until the far end acknowledges it. A retry request from the far end makes the sender replay from the named packet onward. Replay starts only after the packet being sent is complete.

On the receive side it runs the same CRC over each arriving packet at line rate and holds the flits in a staging store until the trailer has been checked. A packet is released as one wide word only when its CRC is good and its sequence number is the one expected next. Each good packet returns a cumulative acknowledge on the sideband. A bad CRC returns a retry request naming the expected sequence number. Packets with a good CRC but the wrong sequence number are dropped without any message. This gives go-back-N ordering per hop, and the error-free path carries no extra delay.

Top module: `link_retry_engine`

## Requirements
- R1: A link packet is 17 beats of 65 bits on tx_data: sixteen data beats and then one trailer beat. The trailer carries the CRC in bits [15:0] and the sequence number in bits [23:16], and bits [64:24] are zero. Logically the packet is 1040 payload bits plus a 16-bit CRC (1056 bits).
- R2: The CRC uses polynomial 0x1021 and starts at 0xFFFF. It is processed bit-serially, most significant bit first, over each data beat's 65 bits (bit 64 first) and then over the 65-bit word that holds the sequence number zero-extended. The trailer appears in the cycle right after the last data beat, with no stall.
- R3: A flit accepted on in_valid && in_ready appears on tx_data in the following cycle, with tx_valid high.
- R4: Sequence numbers of new packets start at 0 after reset and increase by 1 per packet, modulo 256.
- R5: Up to 8 unacknowledged packets are kept. While 8 are outstanding, in_ready is low at the start of a packet. An acknowledge (sbi_retry=0) with sequence a frees every packet older than a, and in_ready rises in the next cycle.
- R6: A received packet with a good CRC and the expected sequence number raises dly_valid for one cycle, in the cycle after its trailer. Flit i is in dly_pkt[i*65 +: 65] and dly_seq is the packet's sequence number. In the same cycle an acknowledge (sbo_retry=0) is sent with sbo_seq equal to the next expected sequence number.
- R7: A packet with a bad CRC is never delivered. In the cycle after its trailer, a retry request (sbo_retry=1) is sent with sbo_seq equal to the expected sequence number.
- R8: When the sender receives a valid retry request, it finishes the packet in progress. It then resends the requested packet and every newer one from the replay store, with their original sequence numbers and contents, and only then accepts new flits.
- R9: A received packet with a good CRC but an unexpected sequence number is dropped. It produces no delivery and no sideband message.
- R10: An incoming acknowledge or retry request whose sequence number lies outside the window of outstanding packets is ignored. Such a request starts no transmission and leaves in_ready unchanged.
- R11: After reset, tx_valid, dly_valid and sbo_valid are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Flit offered |
| in_ready | output | 1 | Flit accepted this cycle when high with in_valid |
| in_flit | input | 65 | Flit to send |
| tx_valid | output | 1 | Beat on tx_data valid |
| tx_data | output | 65 | Outgoing packet beat (data or trailer) |
| rx_valid | input | 1 | Beat on rx_data valid |
| rx_data | input | 65 | Incoming packet beat from far end |
| dly_valid | output | 1 | One-cycle pulse: good packet delivered |
| dly_seq | output | 8 | Sequence number of delivered packet |
| dly_pkt | output | 1040 | Delivered payload, flit i at [i*65 +: 65] |
| sbo_valid | output | 1 | Sideband message to far end valid |
| sbo_retry | output | 1 | 1 = retry request, 0 = acknowledge |
| sbo_seq | output | 8 | Sideband sequence number |
| sbi_valid | input | 1 | Sideband message from far end valid |
| sbi_retry | input | 1 | 1 = retry request, 0 = acknowledge |
| sbi_seq | input | 8 | Sideband sequence number from far end |

## Verification
The bench loops the transmit stream back into the receive side through a bit-flip injector, and sends the sideband back either directly or from bench-driven messages. A flit must appear on tx_data one cycle after the edge that accepts it (R3). The trailer must follow the sixteenth data beat in the next cycle (R2). dly_valid and every sideband message must come exactly one cycle after a trailer cycle, so each is checked against a flag recorded in the previous cycle. Buffer-full blocking and its release are sampled one cycle after the acknowledge is driven. Replay and dropping depend on the retry round trip, so they are checked by counting trailers per sequence number and comparing delivery and message counts once the stream has settled.

// File: rtl/link_retry_engine.sv
module link_retry_engine #(
  parameter int FLIT_W   = 65,
  parameter int FLITS    = 16,
  parameter int CRC_W    = 16,
  parameter int SEQ_W    = 8,
  parameter int BUF_PKTS = 8,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [FLIT_W-1:0]       in_flit,
  output logic                    tx_valid,
  output logic [FLIT_W-1:0]       tx_data,
  input  logic                    rx_valid,
  input  logic [FLIT_W-1:0]       rx_data,
  output logic                    dly_valid,
  output logic [SEQ_W-1:0]        dly_seq,
  output logic [FLITS*FLIT_W-1:0] dly_pkt,
  output logic                    sbo_valid,
  output logic                    sbo_retry,
  output logic [SEQ_W-1:0]        sbo_seq,
  input  logic                    sbi_valid,
  input  logic                    sbi_retry,
  input  logic [SEQ_W-1:0]        sbi_seq
);
  localparam int BEAT_W = $clog2(FLITS + 1);
  localparam int FI_W   = $clog2(FLITS);
  localparam int IDX_W  = $clog2(BUF_PKTS);
  localparam int PAD_W  = FLIT_W - SEQ_W - CRC_W;
  localparam logic [BEAT_W-1:0] TRL = BEAT_W'(FLITS);

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [FLIT_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int k = FLIT_W - 1; k >= 0; k--) begin
      fb = r[CRC_W-1] ^ d[k];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction

  // transmit side
  logic [FLIT_W-1:0] mem [BUF_PKTS*FLITS];
  logic [BEAT_W-1:0] tx_beat;
  logic [SEQ_W-1:0]  wr_seq, ack_seq, rp_seq, pend_seq;
  logic              replay, pend;
  logic [CRC_W-1:0]  tx_crc;

  logic [SEQ_W-1:0]  in_flight, sbi_d, cur_seq, rp_nxt;
  logic              at_trl, go_apply, in_fire, data_fire;
  logic [FLIT_W-1:0] rp_rd, beat_data, trailer;
  logic [CRC_W-1:0]  tx_crc_fin;

  assign in_flight  = wr_seq - ack_seq;
  assign sbi_d      = sbi_seq - ack_seq;
  assign at_trl     = tx_beat == TRL;
  assign go_apply   = pend && tx_beat == '0;
  assign in_ready   = !replay && !at_trl &&
                      !(tx_beat == '0 && (pend || in_flight == SEQ_W'(BUF_PKTS)));
  assign in_fire    = in_valid && in_ready;
  assign data_fire  = !at_trl && (replay ? !go_apply : in_fire);
  assign rp_rd      = mem[{rp_seq[IDX_W-1:0], tx_beat[FI_W-1:0]}];
  assign beat_data  = replay ? rp_rd : in_flit;
  assign cur_seq    = replay ? rp_seq : wr_seq;
  assign rp_nxt     = rp_seq + 1'b1;
  assign tx_crc_fin = crc_step(tx_crc, {{(FLIT_W-SEQ_W){1'b0}}, cur_seq});
  assign trailer    = {{PAD_W{1'b0}}, cur_seq, tx_crc_fin};

  always_ff @(posedge clk)
    if (in_fire) mem[{wr_seq[IDX_W-1:0], tx_beat[FI_W-1:0]}] <= in_flit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_beat  <= '0;
      tx_crc   <= INIT;
      wr_seq   <= '0;
      ack_seq  <= '0;
      rp_seq   <= '0;
      pend_seq <= '0;
      replay   <= 1'b0;
      pend     <= 1'b0;
    end else begin
      tx_valid <= data_fire || at_trl;
      if (data_fire) begin
        tx_data <= beat_data;
        tx_crc  <= crc_step((tx_beat == '0) ? INIT : tx_crc, beat_data);
        tx_beat <= tx_beat + 1'b1;
      end
      if (at_trl) begin
        tx_data <= trailer;
        tx_beat <= '0;
        if (replay) begin
          rp_seq <= rp_nxt;
          if (rp_nxt == wr_seq) replay <= 1'b0;
        end else begin
          wr_seq <= wr_seq + 1'b1;
        end
      end
      if (go_apply) begin
        replay <= 1'b1;
        rp_seq <= pend_seq;
        pend   <= 1'b0;
      end
      if (sbi_valid && sbi_d <= in_flight) begin
        ack_seq <= sbi_seq;
        if (sbi_retry && sbi_d != in_flight) begin
          pend     <= 1'b1;
          pend_seq <= sbi_seq;
        end
      end
    end
  end

  // receive side
  logic [FLIT_W-1:0] stage [FLITS];
  logic [BEAT_W-1:0] rx_beat;
  logic [CRC_W-1:0]  rx_crc;
  logic [SEQ_W-1:0]  exp_seq, rx_seq_f;
  logic              rx_trl, crc_ok, seq_ok;

  assign rx_trl   = rx_beat == TRL;
  assign rx_seq_f = rx_data[CRC_W +: SEQ_W];
  assign crc_ok   = crc_step(rx_crc, {{(FLIT_W-SEQ_W){1'b0}}, rx_seq_f}) == rx_data[CRC_W-1:0];
  assign seq_ok   = rx_seq_f == exp_seq;
  assign dly_seq  = exp_seq - 1'b1;

  for (genvar g = 0; g < FLITS; g++) begin : g_flat
    assign dly_pkt[g*FLIT_W +: FLIT_W] = stage[g];
  end

  always_ff @(posedge clk)
    if (rx_valid && !rx_trl) stage[rx_beat[FI_W-1:0]] <= rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_beat   <= '0;
      rx_crc    <= INIT;
      exp_seq   <= '0;
      dly_valid <= 1'b0;
      sbo_valid <= 1'b0;
      sbo_retry <= 1'b0;
      sbo_seq   <= '0;
    end else begin
      dly_valid <= 1'b0;
      sbo_valid <= 1'b0;
      if (rx_valid) begin
        if (!rx_trl) begin
          rx_crc  <= crc_step((rx_beat == '0) ? INIT : rx_crc, rx_data);
          rx_beat <= rx_beat + 1'b1;
        end else begin
          rx_beat <= '0;
          if (crc_ok && seq_ok) begin
            dly_valid <= 1'b1;
            exp_seq   <= exp_seq + 1'b1;
            sbo_valid <= 1'b1;
            sbo_retry <= 1'b0;
            sbo_seq   <= exp_seq + 1'b1;
          end else if (!crc_ok) begin
            sbo_valid <= 1'b1;
            sbo_retry <= 1'b1;
            sbo_seq   <= exp_seq;
          end
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight <= SEQ_W'(BUF_PKTS)); // R5
  AST_REPLAY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    replay |-> (SEQ_W'(rp_seq - ack_seq) < in_flight)); // R8
  AST_DELIVER_AFTER_TRAILER: assert property (@(posedge clk) disable iff (!rst_n)
    dly_valid |-> ($past(rx_valid) && $past(rx_beat) == TRL)); // R6
  AST_EXP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_seq != $past(exp_seq)) |-> (dly_valid && exp_seq == SEQ_W'($past(exp_seq) + 1'b1))); // R6
  AST_SB_AFTER_TRAILER: assert property (@(posedge clk) disable iff (!rst_n)
    sbo_valid |-> ($past(rx_valid) && $past(rx_beat) == TRL)); // R7
  AST_NO_BAD_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
    !(dly_valid && sbo_retry)); // R7
endmodule

// File: tb/link_retry_engine_tb.sv
`timescale 1ns/1ps
module link_retry_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        in_valid = 1'b0, in_ready;
  logic [64:0] in_flit = '0;
  logic        tx_valid, rx_valid;
  logic [64:0] tx_data, rx_data;
  logic        dly_valid;
  logic [7:0]  dly_seq;
  logic [1039:0] dly_pkt;
  logic        sbo_valid, sbo_retry, sbi_valid, sbi_retry;
  logic [7:0]  sbo_seq, sbi_seq;
  logic        sbsel = 1'b0, b_valid = 1'b0, b_retry = 1'b0;
  logic [7:0]  b_seq = '0;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int mon_beat = 0, tcount = 0, del_cnt = 0, nret = 0, nsb = 0;
  int inj_idx = -1;
  int seqcnt [256];
  logic [64:0] cap [16];
  bit prev_trl = 0;

  assign rx_valid  = tx_valid;
  assign rx_data   = tx_data ^ ((tcount == inj_idx && mon_beat == 3) ? 65'h80 : 65'h0);
  assign sbi_valid = sbsel ? b_valid : sbo_valid;
  assign sbi_retry = sbsel ? b_retry : sbo_retry;
  assign sbi_seq   = sbsel ? b_seq   : sbo_seq;

  link_retry_engine u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .dly_valid(dly_valid), .dly_seq(dly_seq), .dly_pkt(dly_pkt),
    .sbo_valid(sbo_valid), .sbo_retry(sbo_retry), .sbo_seq(sbo_seq),
    .sbi_valid(sbi_valid), .sbi_retry(sbi_retry), .sbi_seq(sbi_seq));

  function automatic logic [64:0] gen(input int p, input int i);
    return {1'(p ^ i), 8'(p), 8'(i), 48'(p * 48'h1_0001 + i * 48'h00FF_00FF + 48'h5A5A)};
  endfunction

  function automatic logic [15:0] crc16(input logic [15:0] c, input logic [64:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int k = 64; k >= 0; k--) begin
      fb = r[15] ^ d[k];
      r  = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_valid) begin
      mon_beat <= (mon_beat == 16) ? 0 : mon_beat + 1;
      if (mon_beat == 16) tcount <= tcount + 1;
    end
    if (cyc > 100000) begin
      check(0, "watchdog", 65'(cyc), 65'd100000);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (dly_valid) begin
        check(prev_trl, "R6 delivery one cycle after trailer", 65'(prev_trl), 65'd1);
        check(dly_seq == 8'(del_cnt), "R6 delivered seq in order", 65'(dly_seq), 65'(del_cnt));
        for (int i = 0; i < 16; i++)
          if (dly_pkt[i*65 +: 65] != gen(del_cnt, i))
            check(0, "R7 delivered flit content", dly_pkt[i*65 +: 65], gen(del_cnt, i));
        del_cnt++;
      end
      if (sbo_valid) begin
        nsb++;
        check(prev_trl, "R7 sideband one cycle after trailer", 65'(prev_trl), 65'd1);
        if (sbo_retry) begin
          nret++;
          check(sbo_seq == 8'(del_cnt), "R7 retry names expected seq", 65'(sbo_seq), 65'(del_cnt));
        end else
          check(sbo_seq == 8'(del_cnt), "R6 ack names next expected", 65'(sbo_seq), 65'(del_cnt));
      end
      if (tx_valid && mon_beat < 16) cap[mon_beat] = tx_data;
      if (tx_valid && mon_beat == 16) begin
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < 16; i++) c = crc16(c, cap[i]);
        c = crc16(c, {57'd0, tx_data[23:16]});
        check(tx_data[15:0] == c, "R2 trailer CRC", 65'(tx_data[15:0]), 65'(c));
        check(tx_data[64:24] == '0, "R1 trailer padding", 65'(tx_data[64:24]), 65'd0);
        seqcnt[tx_data[23:16]]++;
      end
      prev_trl = tx_valid && mon_beat == 16;
    end
  end

  task automatic send_pkt(input int p, input bit chk_lat);
    for (int i = 0; i < 16; i++) begin
      in_valid = 1'b1;
      in_flit  = gen(p, i);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (chk_lat)
        check(tx_valid && tx_data == gen(p, i), "R3 flit one cycle after accept", tx_data, gen(p, i));
      if (chk_lat && i == 15) begin
        @(negedge clk);
        check(tx_valid && mon_beat == 16 && tx_data[23:16] == 8'(p),
              "R2 R4 trailer right after last beat with seq", tx_data, 65'(p));
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_del(input int n);
    int lim;
    lim = 0;
    while (del_cnt < n && lim < 3000) begin
      @(negedge clk);
      lim++;
    end
    check(del_cnt >= n, "R6 deliveries complete", 65'(del_cnt), 65'(n));
    repeat (6) @(negedge clk);
  endtask

  task automatic sb_drive(input bit retry, input int s);
    b_valid = 1'b1; b_retry = retry; b_seq = 8'(s);
    @(negedge clk);
    b_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(in_ready === 1'b1, "R11 in_ready after reset", 65'(in_ready), 65'd1);
    check(tx_valid === 1'b0, "R11 tx_valid after reset", 65'(tx_valid), 65'd0);
    check(dly_valid === 1'b0, "R11 dly_valid after reset", 65'(dly_valid), 65'd0);
    check(sbo_valid === 1'b0, "R11 sbo_valid after reset", 65'(sbo_valid), 65'd0);
  endtask

  task automatic t_clean();
    for (int p = 0; p < 4; p++) send_pkt(p, 1'b1);
    wait_del(4);
    check(nret == 0, "R6 no retry on clean link", 65'(nret), 65'd0);
  endtask

  task automatic t_error();
    inj_idx = tcount + 1;
    for (int p = 4; p < 10; p++) send_pkt(p, 1'b0);
    wait_del(10);
    check(nret == 1, "R7 one retry after one bad packet", 65'(nret), 65'd1);
    check(seqcnt[5] == 2, "R8 bad packet resent", 65'(seqcnt[5]), 65'd2);
    check(tcount - del_cnt - nret >= 1, "R9 good out-of-order packet dropped",
          65'(tcount - del_cnt - nret), 65'd1);
    check(nsb == del_cnt + nret, "R9 no sideband for dropped packet", 65'(nsb), 65'(del_cnt + nret));
  endtask

  task automatic t_full();
    sbsel = 1'b1;
    for (int p = 10; p < 18; p++) send_pkt(p, 1'b0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 0 || k == 19)
        check(in_ready == 1'b0, "R5 blocked with 8 outstanding", 65'(in_ready), 65'd0);
    end
    wait_del(18);
    sb_drive(1'b0, 18);
    check(in_ready == 1'b1, "R5 ack frees buffer next cycle", 65'(in_ready), 65'd1);
  endtask

  task automatic t_window();
    int seen;
    seen = 0;
    sb_drive(1'b1, 118);
    sb_drive(1'b1, 17);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (tx_valid) seen++;
    end
    check(seen == 0, "R10 out-of-window retry ignored", 65'(seen), 65'd0);
    check(in_ready == 1'b1, "R10 in_ready unchanged", 65'(in_ready), 65'd1);
  endtask

  task automatic t_replay();
    int sb0;
    send_pkt(18, 1'b0);
    send_pkt(19, 1'b0);
    wait_del(20);
    sb0 = nsb;
    sb_drive(1'b1, 18);
    repeat (60) @(negedge clk);
    check(seqcnt[18] == 2 && seqcnt[19] == 2, "R8 replay from requested seq",
          65'(seqcnt[18] * 10 + seqcnt[19]), 65'd22);
    check(del_cnt == 20, "R9 replayed duplicates not delivered", 65'(del_cnt), 65'd20);
    check(nsb == sb0, "R9 no sideband for duplicates", 65'(nsb), 65'(sb0));
    sb_drive(1'b0, 20);
    sbsel = 1'b0;
    send_pkt(20, 1'b1);
    send_pkt(21, 1'b1);
    wait_del(22);
    check(seqcnt[21] == 1, "R4 new packets resume after replay", 65'(seqcnt[21]), 65'd1);
  endtask

  initial begin
    foreach (seqcnt[i]) seqcnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_error();
    t_full();
    t_window();
    t_replay();
    finish_run();
  end
endmodule